// File: doc/BRIEF.md
# Port Zero I/O Controller

This block manages one 8-bit bidirectional pin group of an 8051-class microcontroller. It holds an output latch and a per-pin pull-up control register, plus an analog-select register. All three sit on a simple special-function-register bus with an address, a write strobe, a read strobe and a read-modify-write qualifier. For every pin it produces an output enable, an output data value and a pull-up enable. It also brings each pin's level back to the bus through a two-flop synchronizer.

Pins are open-drain by default. A latch bit of 0 pulls its pin low, and a latch bit of 1 lets it float. The lowest pin can be handed to an analog converter. When that happens its digital input is masked. While the converter is also enabled, its pull-up is cut as well.

When the core uses the port as a multiplexed external address/data bus, the block drives the bus byte supplied by the bus interface, or releases all pins for a read phase. During that time the latch is reloaded with all ones on every clock.

Top module: `pz_io_ctrl`

## Requirements
- R1: Reset state:
  - the output latch (address 80h) and the pull-up control register (address E4h) are FFh;
  - the analog-select register (address E2h) is 00h;
  - the input synchronizer holds zeros.
  
  As a result, no pin is driven, no pull-up is on, and `adc_ain_en` is 0.
- R2: A write strobe with address 80h loads the latch on the next clock edge. Outside external access:
  - `pad_oe[i]` is the inverse of latch bit i;
  - `pad_do` is always 00h, so a pin is never driven high.
- R3: A write to E4h loads the pull-up control register. Outside the analog override, `pad_pu_en[i]` is 1 exactly when register bit i is 0.
- R4: A write to E2h loads the analog-select register. Bit 0 of that register is output on `adc_ain_en`. While that bit is 1, a plain read of 80h returns 0 in bit 0.
- R5: While `adc_en` is 1 and analog-select bit 0 is 1, `pad_pu_en[0]` is 0, whatever the pull-up register holds.
- R6: On every clock edge with `xbus_active` high, the latch is loaded with FFh. A write to 80h in such a cycle has no effect.
- R7: While `xbus_active` is high:
  - with `xbus_oe` high, `pad_oe` is FFh and `pad_do` equals `xbus_out`;
  - with `xbus_oe` low, `pad_oe` is 00h and `pad_do` is 00h.
  
  `xbus_rdata` always equals `pad_in`.
- R8: A read of 80h with `reg_rmw` high returns the latch contents, not the pins.
- R9: A read of 80h with `reg_rmw` low returns the pin levels as they were sampled two clock edges earlier.
- R10: Reads of E4h and E2h return the stored values. A read of any other address returns 00h, and so does `reg_rdata` whenever `reg_rd` is low. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rmw | input | 1 | Read-modify-write qualifier for reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| adc_en | input | 1 | Converter enable flag |
| xbus_active | input | 1 | External memory access in progress |
| xbus_oe | input | 1 | External access drives the pins (address/write data phase) |
| xbus_out | input | 8 | Address or data byte to place on the pins |
| xbus_rdata | output | 8 | Pin levels returned to the external bus interface |
| pad_in | input | 8 | Pin levels from the pads |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_do | output | 8 | Per-pin output value |
| pad_pu_en | output | 8 | Per-pin pull-up enable |
| adc_ain_en | output | 1 | Analog path enable for pin 0 |

## Verification
The main function is tried with directed patterns first:
- walking-zero latch values, which show that each latch bit controls only its own pin driver;
- alternating pin patterns read both plainly and with the read-modify-write qualifier, which tell latch readback apart from pin readback and expose the two-cycle synchronizer delay;
- external-access bursts with writes attempted inside them, which separate the forced reload from an ordinary write.

Analog-select on and off, crossed with the converter enable, distinguishes input masking from pull-up cutting. A long pseudo-random phase then mixes all addresses, strobes and modes, and compares every output against the reference model on each clock.

// File: rtl/pz_io_pkg.sv
package pz_io_pkg;

   typedef enum logic [1:0] {
      PZ_SEL_NONE  = 2'd0,
      PZ_SEL_LATCH = 2'd1,
      PZ_SEL_PULL  = 2'd2,
      PZ_SEL_ASEL  = 2'd3
   } pz_sel_e;

   function automatic pz_sel_e pz_decode(input logic [7:0] addr,
                                         input logic [7:0] a_latch,
                                         input logic [7:0] a_pull,
                                         input logic [7:0] a_asel);
      if (addr == a_latch)     return PZ_SEL_LATCH;
      else if (addr == a_pull) return PZ_SEL_PULL;
      else if (addr == a_asel) return PZ_SEL_ASEL;
      else                     return PZ_SEL_NONE;
   endfunction

endpackage

// File: rtl/pz_io_regs.sv
module pz_io_regs
   import pz_io_pkg::*;
#(
   parameter int         WIDTH      = 8,
   parameter int         ADDR_W     = 8,
   parameter logic [7:0] LATCH_ADDR = 8'h80,
   parameter logic [7:0] PULL_ADDR  = 8'hE4,
   parameter logic [7:0] ASEL_ADDR  = 8'hE2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [WIDTH-1:0]  reg_wdata,
   input  logic              xbus_active,
   output pz_sel_e           sel,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  pull_q,
   output logic [WIDTH-1:0]  asel_q
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ALL_ZERO = {WIDTH{1'b0}};

   logic wr_latch, wr_pull, wr_asel;

   always_comb begin
      sel      = pz_decode(8'(reg_addr), LATCH_ADDR, PULL_ADDR, ASEL_ADDR);
      wr_latch = reg_wr && (sel == PZ_SEL_LATCH);
      wr_pull  = reg_wr && (sel == PZ_SEL_PULL);
      wr_asel  = reg_wr && (sel == PZ_SEL_ASEL);
   end

   // External access owns the latch: reload to all ones beats any write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           latch_q <= ALL_ONES;
      else if (xbus_active) latch_q <= ALL_ONES;
      else if (wr_latch)    latch_q <= reg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pull_q <= ALL_ONES;
      else if (wr_pull) pull_q <= reg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       asel_q <= ALL_ZERO;
      else if (wr_asel) asel_q <= reg_wdata;
   end

endmodule

// File: rtl/pz_io_sync.sv
module pz_io_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= din;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[k] <= '0;
         else        stage_q[k] <= stage_q[k-1];
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pz_io_pad.sv
module pz_io_pad #(
   parameter int WIDTH       = 8,
   parameter int ANALOG_BITS = 1
) (
   input  logic [WIDTH-1:0]       latch_q,
   input  logic [WIDTH-1:0]       pull_q,
   input  logic [ANALOG_BITS-1:0] asel_lo,
   input  logic                   adc_en,
   input  logic                   xbus_active,
   input  logic                   xbus_oe,
   input  logic [WIDTH-1:0]       xbus_out,
   output logic [WIDTH-1:0]       pad_oe,
   output logic [WIDTH-1:0]       pad_do,
   output logic [WIDTH-1:0]       pad_pu_en,
   output logic [WIDTH-1:0]       din_en
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic analog;

      if (i < ANALOG_BITS) begin : g_ana
         assign analog = asel_lo[i];
      end else begin : g_dig
         assign analog = 1'b0;
      end

      always_comb begin
         din_en[i]    = !analog;
         pad_pu_en[i] = !pull_q[i] && !(analog && adc_en);
         if (xbus_active) begin
            pad_oe[i] = xbus_oe;
            pad_do[i] = xbus_oe && xbus_out[i];
         end else begin
            pad_oe[i] = !latch_q[i];
            pad_do[i] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/pz_io_rdmux.sv
module pz_io_rdmux
   import pz_io_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             reg_rd,
   input  logic             reg_rmw,
   input  pz_sel_e          sel,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] pull_q,
   input  logic [WIDTH-1:0] asel_q,
   input  logic [WIDTH-1:0] pin_sync,
   input  logic [WIDTH-1:0] din_en,
   output logic [WIDTH-1:0] reg_rdata
);

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         unique case (sel)
            PZ_SEL_LATCH: reg_rdata = reg_rmw ? latch_q : (pin_sync & din_en);
            PZ_SEL_PULL:  reg_rdata = pull_q;
            PZ_SEL_ASEL:  reg_rdata = asel_q;
            default:      reg_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/pz_io_ctrl.sv
module pz_io_ctrl
   import pz_io_pkg::*;
#(
   parameter int         WIDTH       = 8,
   parameter int         ADDR_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         ANALOG_BITS = 1,
   parameter logic [7:0] LATCH_ADDR  = 8'h80,
   parameter logic [7:0] PULL_ADDR   = 8'hE4,
   parameter logic [7:0] ASEL_ADDR   = 8'hE2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic                   reg_wr,
   input  logic                   reg_rd,
   input  logic                   reg_rmw,
   input  logic [WIDTH-1:0]       reg_wdata,
   output logic [WIDTH-1:0]       reg_rdata,
   input  logic                   adc_en,
   input  logic                   xbus_active,
   input  logic                   xbus_oe,
   input  logic [WIDTH-1:0]       xbus_out,
   output logic [WIDTH-1:0]       xbus_rdata,
   input  logic [WIDTH-1:0]       pad_in,
   output logic [WIDTH-1:0]       pad_oe,
   output logic [WIDTH-1:0]       pad_do,
   output logic [WIDTH-1:0]       pad_pu_en,
   output logic [ANALOG_BITS-1:0] adc_ain_en
);

   // Elaboration-time parameter checks.
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pz_io_ctrl: SYNC_STAGES must be at least 2");
   end
   if (ANALOG_BITS < 1 || ANALOG_BITS > WIDTH) begin : g_bad_ana
      $error("pz_io_ctrl: ANALOG_BITS must lie in 1..WIDTH");
   end
   if (ADDR_W != 8) begin : g_bad_addr
      $error("pz_io_ctrl: ADDR_W must be 8");
   end
   if (LATCH_ADDR == PULL_ADDR || LATCH_ADDR == ASEL_ADDR || PULL_ADDR == ASEL_ADDR) begin : g_bad_map
      $error("pz_io_ctrl: register addresses must be distinct");
   end

   pz_sel_e          sel;
   logic [WIDTH-1:0] latch_q, pull_q, asel_q;
   logic [WIDTH-1:0] pin_sync, din_en;

   pz_io_regs #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W),
      .LATCH_ADDR(LATCH_ADDR), .PULL_ADDR(PULL_ADDR), .ASEL_ADDR(ASEL_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .xbus_active(xbus_active), .sel(sel),
      .latch_q(latch_q), .pull_q(pull_q), .asel_q(asel_q)
   );

   pz_io_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
   );

   pz_io_pad #(.WIDTH(WIDTH), .ANALOG_BITS(ANALOG_BITS)) u_pad (
      .latch_q(latch_q), .pull_q(pull_q), .asel_lo(asel_q[ANALOG_BITS-1:0]),
      .adc_en(adc_en), .xbus_active(xbus_active), .xbus_oe(xbus_oe),
      .xbus_out(xbus_out), .pad_oe(pad_oe), .pad_do(pad_do),
      .pad_pu_en(pad_pu_en), .din_en(din_en)
   );

   pz_io_rdmux #(.WIDTH(WIDTH)) u_rdmux (
      .reg_rd(reg_rd), .reg_rmw(reg_rmw), .sel(sel), .latch_q(latch_q),
      .pull_q(pull_q), .asel_q(asel_q), .pin_sync(pin_sync),
      .din_en(din_en), .reg_rdata(reg_rdata)
   );

   assign xbus_rdata = pad_in;
   assign adc_ain_en = asel_q[ANALOG_BITS-1:0];

endmodule

// File: rtl/pz_io_chk.sv
module pz_io_chk #(
   parameter int         WIDTH       = 8,
   parameter int         ADDR_W      = 8,
   parameter int         ANALOG_BITS = 1,
   parameter logic [7:0] LATCH_ADDR  = 8'h80
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic                   reg_rd,
   input logic                   reg_rmw,
   input logic [WIDTH-1:0]       reg_rdata,
   input logic                   adc_en,
   input logic                   xbus_active,
   input logic                   xbus_oe,
   input logic [WIDTH-1:0]       xbus_out,
   input logic [WIDTH-1:0]       pad_in,
   input logic [WIDTH-1:0]       pad_oe,
   input logic [WIDTH-1:0]       pad_do,
   input logic [WIDTH-1:0]       pad_pu_en,
   input logic [ANALOG_BITS-1:0] adc_ain_en
);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 3) since_rst <= since_rst + 2'd1;
   end

   logic rd_latch_rmw, rd_latch_pin;
   assign rd_latch_rmw = reg_rd && reg_rmw && (8'(reg_addr) == LATCH_ADDR);
   assign rd_latch_pin = reg_rd && !reg_rmw && (8'(reg_addr) == LATCH_ADDR);

   a_r2_no_high_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !xbus_active |-> pad_do == '0);

   a_r2_oe_tracks_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (!xbus_active && rd_latch_rmw) |-> pad_oe == ~reg_rdata);

   a_r5_pull_cut: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_en && adc_ain_en[0]) |-> !pad_pu_en[0]);

   a_r4_din_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_latch_pin && adc_ain_en[0]) |-> !reg_rdata[0]);

   a_r6_forced_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (xbus_active ##1 rd_latch_rmw) |-> reg_rdata == '1);

   a_r7_bus_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (xbus_active && xbus_oe) |-> (pad_oe == '1 && pad_do == xbus_out));

   a_r7_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
      (xbus_active && !xbus_oe) |-> pad_oe == '0);

   a_r9_two_flop: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3 && rd_latch_pin && !adc_ain_en[0]) |-> reg_rdata == $past(pad_in, 2));

endmodule

bind pz_io_ctrl pz_io_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .ANALOG_BITS(ANALOG_BITS), .LATCH_ADDR(LATCH_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
   .reg_rmw(reg_rmw), .reg_rdata(reg_rdata), .adc_en(adc_en),
   .xbus_active(xbus_active), .xbus_oe(xbus_oe), .xbus_out(xbus_out),
   .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do),
   .pad_pu_en(pad_pu_en), .adc_ain_en(adc_ain_en)
);

// File: tb/pz_io_ctrl_tb_top.sv
module pz_io_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_rmw = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       adc_en = 1'b0;
   logic       xbus_active = 1'b0, xbus_oe = 1'b0;
   logic [7:0] xbus_out = '0;
   logic [7:0] xbus_rdata;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_oe, pad_do, pad_pu_en;
   logic [0:0] adc_ain_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pz_io_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_rmw(reg_rmw), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .adc_en(adc_en), .xbus_active(xbus_active),
      .xbus_oe(xbus_oe), .xbus_out(xbus_out), .xbus_rdata(xbus_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do),
      .pad_pu_en(pad_pu_en), .adc_ain_en(adc_ain_en)
   );

   // Behavioural reference model
   logic [7:0] m_latch, m_pull, m_asel;
   logic [7:0] m_hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_latch = 8'hFF; m_pull = 8'hFF; m_asel = 8'h00;
         m_hist  = '{8'h00, 8'h00};
      end else begin
         if (xbus_active)                  m_latch = 8'hFF;
         else if (reg_wr && reg_addr == 8'h80) m_latch = reg_wdata;
         if (reg_wr && reg_addr == 8'hE4)  m_pull = reg_wdata;
         if (reg_wr && reg_addr == 8'hE2)  m_asel = reg_wdata;
         m_hist.push_back(pad_in);
         void'(m_hist.pop_front());
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [7:0] e_oe, e_do, e_pu, e_rd;
         if (xbus_active) begin
            e_oe = xbus_oe ? 8'hFF : 8'h00;
            e_do = xbus_oe ? xbus_out : 8'h00;
         end else begin
            e_oe = ~m_latch;
            e_do = 8'h00;
         end
         e_pu = ~m_pull;
         if (m_asel[0] && adc_en) e_pu[0] = 1'b0;
         e_rd = 8'h00;
         if (reg_rd) begin
            if (reg_addr == 8'h80) begin
               e_rd = reg_rmw ? m_latch : m_hist[0];
               if (!reg_rmw && m_asel[0]) e_rd[0] = 1'b0;
            end else if (reg_addr == 8'hE4) e_rd = m_pull;
            else if (reg_addr == 8'hE2)     e_rd = m_asel;
         end
         chk("R2/R6/R7 pad_oe", pad_oe, e_oe);
         chk("R2/R7 pad_do", pad_do, e_do);
         chk("R3/R5 pad_pu_en", pad_pu_en, e_pu);
         chk("R4 adc_ain_en", {7'd0, adc_ain_en}, {7'd0, m_asel[0]});
         chk("R4/R8/R9/R10 reg_rdata", reg_rdata, e_rd);
         chk("R7 xbus_rdata", xbus_rdata, pad_in);
      end
   end

   task automatic bus(input logic [7:0] a, input bit wr, input bit rd,
                      input bit rmw, input logic [7:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wr = wr; reg_rd = rd; reg_rmw = rmw; reg_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) bus(8'h00, 0, 0, 0, 8'h00);
   endtask

   int unsigned seed = 32'h1234_5678;
   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed >> 8;
   endfunction

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset values visible on the ports
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 pad_oe in reset", pad_oe, 8'h00);
      chk("R1 pad_pu_en in reset", pad_pu_en, 8'h00);
      chk("R1 adc_ain_en in reset", {7'd0, adc_ain_en}, 8'h00);
      @(posedge clk); #1; rst_n = 1'b1;
      bus(8'h80, 0, 1, 1, 8'h00); @(negedge clk); chk("R1 latch after reset", reg_rdata, 8'hFF);
      bus(8'hE4, 0, 1, 0, 8'h00); @(negedge clk); chk("R1 pull after reset", reg_rdata, 8'hFF);
      bus(8'hE2, 0, 1, 0, 8'h00); @(negedge clk); chk("R1 asel after reset", reg_rdata, 8'h00);

      // R2: walking zero through the latch
      for (int b = 0; b < 8; b++) begin
         bus(8'h80, 1, 0, 0, ~(8'h01 << b));
         bus(8'h80, 0, 1, 1, 8'h00);
         @(negedge clk); chk("R2 walking-zero oe", pad_oe, 8'h01 << b);
      end
      // R3: pull-up patterns
      bus(8'hE4, 1, 0, 0, 8'h5A); idle(1);
      @(negedge clk); chk("R3 pull pattern", pad_pu_en, 8'hA5);
      // R9: pin patterns, plain read vs R8 rmw read
      pad_in = 8'hC3; idle(3);
      bus(8'h80, 0, 1, 0, 8'h00); @(negedge clk); chk("R9 plain read", reg_rdata, 8'hC3);
      bus(8'h80, 0, 1, 1, 8'h00); @(negedge clk); chk("R8 rmw read", reg_rdata, 8'h7F);
      // R4/R5: analog select with converter enable off and on
      bus(8'hE4, 1, 0, 0, 8'h00);
      bus(8'hE2, 1, 0, 0, 8'h01); idle(1);
      @(negedge clk); chk("R5 pull kept with adc off", {7'd0, pad_pu_en[0]}, 8'h01);
      adc_en = 1'b1; idle(1);
      @(negedge clk); chk("R5 pull cut", {7'd0, pad_pu_en[0]}, 8'h00);
      pad_in = 8'hFF; idle(3);
      bus(8'h80, 0, 1, 0, 8'h00); @(negedge clk); chk("R4 masked bit0", reg_rdata, 8'hFE);
      adc_en = 1'b0;
      bus(8'hE2, 1, 0, 0, 8'h00);
      // R6/R7: external bus bursts with writes attempted inside
      bus(8'h80, 1, 0, 0, 8'h00);
      @(posedge clk); #1; xbus_active = 1'b1; xbus_oe = 1'b1; xbus_out = 8'h3C;
      reg_addr = 8'h80; reg_wr = 1'b1; reg_wdata = 8'h11; reg_rd = 1'b0;
      @(negedge clk); chk("R7 bus drive", pad_do, 8'h3C);
      bus(8'h80, 1, 0, 0, 8'h22); xbus_oe = 1'b0;
      @(negedge clk); chk("R7 bus release", pad_oe, 8'h00);
      @(posedge clk); #1; xbus_active = 1'b0; reg_wr = 1'b0; reg_rd = 1'b1; reg_rmw = 1'b1;
      @(negedge clk); chk("R6 latch forced", reg_rdata, 8'hFF);
      // R10: unmapped addresses
      bus(8'h81, 1, 0, 0, 8'h00);
      bus(8'h81, 0, 1, 0, 8'h00); @(negedge clk); chk("R10 unmapped read", reg_rdata, 8'h00);
      bus(8'h80, 0, 1, 1, 8'h00); @(negedge clk); chk("R10 unmapped write ignored", reg_rdata, 8'hFF);

      // Pseudo-random mix, model compared every clock
      for (int n = 0; n < 3000; n++) begin
         int unsigned r = rnd();
         logic [7:0] a;
         case (r % 5)
            0: a = 8'h80; 1: a = 8'h80; 2: a = 8'hE4; 3: a = 8'hE2;
            default: a = 8'(rnd());
         endcase
         bus(a, (r >> 3) % 3 == 0, (r >> 5) % 2 == 1, (r >> 6) % 2 == 1, 8'(rnd()));
         pad_in      = ((r >> 7) % 4 == 0) ? 8'(rnd()) : pad_in;
         adc_en      = (r >> 9) % 3 != 0;
         xbus_active = (r >> 11) % 7 == 0;
         xbus_oe     = (r >> 12) % 2 == 1;
         xbus_out    = 8'(rnd());
      end
      idle(2);
      finish_run();
   end

endmodule